// File: doc/BRIEF.md
# Delinquent Load Table

This block watches the stream of retired loads and picks out the few load addresses (PCs) that cause most of the long-latency misses. A load PC gets a table entry only when its retirement reports an L2 miss and no entry already holds that PC. Free entries are handed out in strict arrival order, always to the lowest-numbered free slot. Once a PC owns an entry, every later retirement of that PC raises the entry's execution count. Each later retirement that misses also adds its latency to the entry's latency sum. Both counters saturate.

A window counter adds up the retired-instruction counts. When the running total reaches the window size, the table classifies every valid entry in that same cycle. An entry is delinquent when its latency sum is larger than the window's cycle count right-shifted by a programmable amount, and its execution count is larger than a programmable minimum. Delinquent entries keep their slot and PC, and their counters are cleared. All other entries are released. The list of delinquent PCs is published with a one-cycle strobe. It stays unchanged until the next evaluation, where a downstream slice builder can pick it up.

Top module: `dlt_table`

## Requirements
- R1: After a synchronous active-low reset, no entry is valid, `res_valid` is 0 and `res_mask` is all zeros.
- R2: A retired load allocates an entry only when `ld_l2miss` is 1 and no valid entry holds its PC. A load that does not miss never allocates.
- R3: An allocation takes the lowest-numbered free entry, and at most one entry is allocated per cycle. In the result list, entry i owns bit i of `res_mask` and bits [i*PC_W +: PC_W] of `res_pc`.
- R4: While every entry is valid, loads with new PCs are dropped, and held PCs do not change until an evaluation frees entries.
- R5: A load whose PC matches a valid entry adds 1 to that entry's execution count. When the load also missed, it adds `ld_lat` to that entry's latency sum.
- R6: Evaluation happens in the cycle in which the accumulated `ret_cnt` total reaches WINDOW (131072), and any excess is discarded. `res_valid` is 1 for exactly the following cycle. The window's cycle count is the number of clock cycles since the previous evaluation, or since reset, including the evaluation cycle itself.
- R7: An entry is delinquent when it is valid, its latency sum is greater than (window cycles >> `frac_sh`), and its execution count is greater than `min_exec`.
- R8: After an evaluation, exactly the delinquent entries stay valid, with their PCs and with both counters cleared. All other entries become free.
- R9: A load presented in the evaluation cycle is not recorded.
- R10: `res_mask` and `res_pc` keep their values between evaluations.
- R11: The execution count (EXEC_W bits) and the latency sum (SUM_W = 16 bits) saturate at their all-ones values instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A retired load is presented this cycle |
| ld_pc | input | PC_W | PC of the retired load |
| ld_l2miss | input | 1 | The load missed in the L2 cache |
| ld_lat | input | LAT_W | Miss latency of the load in cycles |
| ret_cnt | input | RET_W | Instructions retired this cycle |
| frac_sh | input | SH_W | Right shift that sets the latency threshold as a fraction of window cycles |
| min_exec | input | EXEC_W | Execution count an entry must exceed to be delinquent |
| res_valid | output | 1 | One-cycle strobe: a new result list was published |
| res_mask | output | N_ENT | Bit i set when entry i was found delinquent |
| res_pc | output | N_ENT*PC_W | PC of entry i in slot i |

## Verification
Several properties are checked on every cycle:
- the shape of the result strobe;
- that nothing is allocated without a miss or during an evaluation;
- that at most one entry is allocated per cycle;
- that a full table keeps its PCs;
- that after each evaluation the surviving entries match the published mask, and the list holds between evaluations.

The bench scenarios cover what needs history over a whole window:
- which slot a PC lands in;
- the threshold and minimum-count decision;
- latency saturation deciding the result where wrapping would flip it;
- counters being cleared for survivors, shown by a survivor that no longer qualifies in the next window.

// File: rtl/dlt_pkg.sv
// Package dlt_pkg: default sizes shared by the delinquent load table and its bench.
// Assumes: users override these through module parameters when needed.
package dlt_pkg;
    localparam int DLT_ENTRIES = 16;
    localparam int DLT_PC_W    = 32;
    localparam int DLT_LAT_W   = 12;
    localparam int DLT_EXEC_W  = 16;
    localparam int DLT_SUM_W   = 16;
    localparam int DLT_WINDOW  = 131072;
    localparam int DLT_RET_W   = 4;
    localparam int DLT_SH_W    = 5;
    localparam int DLT_CYC_W   = 32;
endpackage

// File: rtl/dlt_window.sv
// Module dlt_window: adds up retired instructions and fires a one-cycle
// evaluation pulse when the total reaches WINDOW. Any excess over WINDOW is
// dropped. It also counts the cycles of the current window, including the
// evaluation cycle.
// Assumes: WINDOW is larger than the largest ret_cnt value.
module dlt_window #(
    parameter int WINDOW = 131072,
    parameter int RET_W  = 4,
    parameter int CYC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RET_W-1:0] ret_cnt,
    output logic             eval,
    output logic [CYC_W-1:0] cyc_win
);
    localparam int IC_W = $clog2(WINDOW) + 2;

    logic [IC_W-1:0]  icnt_q;
    logic [IC_W-1:0]  icnt_nx;
    logic [CYC_W-1:0] cyc_q;

    // next instruction total and window-end detection
    always_comb begin
        icnt_nx = icnt_q + IC_W'(ret_cnt);
        eval    = (icnt_nx >= IC_W'(WINDOW));
        cyc_win = cyc_q + CYC_W'(1);
    end

    // instruction and cycle counters, restarted at each evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt_q <= '0;
            cyc_q  <= '0;
        end else if (eval) begin
            icnt_q <= '0;
            cyc_q  <= '0;
        end else begin
            icnt_q <= icnt_nx;
            cyc_q  <= cyc_win;
        end
    end
endmodule

// File: rtl/dlt_alloc.sv
// Module dlt_alloc: fixed-priority picker that grants the lowest-numbered
// free entry.
// Assumes: free is a bit vector with one bit per entry.
module dlt_alloc #(
    parameter int N = 16
) (
    input  logic [N-1:0] free,
    output logic [N-1:0] grant
);
    // one-hot grant of the lowest free index
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (free[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dlt_entry.sv
// Module dlt_entry: one table slot. It holds the PC tag, a saturating
// execution count and a saturating miss-latency sum, and reports a hit and
// its delinquency verdict.
// Assumes: alloc is only raised when no entry hits. An evaluation takes
// priority over load updates in the same cycle.
module dlt_entry #(
    parameter int PC_W   = 32,
    parameter int LAT_W  = 12,
    parameter int EXEC_W = 16,
    parameter int SUM_W  = 16,
    parameter int CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic              ld_miss,
    input  logic [LAT_W-1:0]  ld_lat,
    input  logic              alloc,
    input  logic              eval,
    input  logic [CYC_W-1:0]  thr,
    input  logic [EXEC_W-1:0] min_exec,
    output logic              vld,
    output logic [PC_W-1:0]   tag,
    output logic              hit,
    output logic              delinq
);
    localparam int CW = (SUM_W > CYC_W) ? SUM_W : CYC_W;

    logic [EXEC_W-1:0] exec_q;
    logic [SUM_W-1:0]  sum_q;
    logic [SUM_W:0]    sum_wide;
    logic [SUM_W-1:0]  sum_sat;
    logic [EXEC_W-1:0] exec_sat;

    // hit detection, saturating arithmetic and verdict
    always_comb begin
        hit      = vld && ld_valid && (ld_pc == tag);
        sum_wide = {1'b0, sum_q} + (SUM_W+1)'(ld_lat);
        sum_sat  = sum_wide[SUM_W] ? '1 : sum_wide[SUM_W-1:0];
        exec_sat = (&exec_q) ? exec_q : exec_q + EXEC_W'(1);
        delinq   = vld && (CW'(sum_q) > CW'(thr)) && (exec_q > min_exec);
    end

    // slot state: evaluation, hit update or fresh allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            tag    <= '0;
            exec_q <= '0;
            sum_q  <= '0;
        end else if (eval) begin
            vld    <= delinq;
            exec_q <= '0;
            sum_q  <= '0;
        end else if (hit) begin
            exec_q <= exec_sat;
            if (ld_miss) sum_q <= sum_sat;
        end else if (alloc) begin
            vld    <= 1'b1;
            tag    <= ld_pc;
            exec_q <= EXEC_W'(1);
            sum_q  <= SUM_W'(ld_lat);
        end
    end
endmodule

// File: rtl/dlt_table.sv
// Module dlt_table: delinquent load table top. It compares each retired load
// against all tags, allocates free slots on L2 misses, classifies the entries
// at each instruction window and publishes the list of delinquent PCs.
// Assumes: at most one retired load per cycle and a synchronous active-low
// reset.
module dlt_table
    import dlt_pkg::*;
#(
    parameter int N_ENT  = DLT_ENTRIES,
    parameter int PC_W   = DLT_PC_W,
    parameter int LAT_W  = DLT_LAT_W,
    parameter int EXEC_W = DLT_EXEC_W,
    parameter int SUM_W  = DLT_SUM_W,
    parameter int WINDOW = DLT_WINDOW,
    parameter int RET_W  = DLT_RET_W,
    parameter int SH_W   = DLT_SH_W,
    parameter int CYC_W  = DLT_CYC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid,
    input  logic [PC_W-1:0]       ld_pc,
    input  logic                  ld_l2miss,
    input  logic [LAT_W-1:0]      ld_lat,
    input  logic [RET_W-1:0]      ret_cnt,
    input  logic [SH_W-1:0]       frac_sh,
    input  logic [EXEC_W-1:0]     min_exec,
    output logic                  res_valid,
    output logic [N_ENT-1:0]      res_mask,
    output logic [N_ENT*PC_W-1:0] res_pc
);
    localparam int LIST_W = N_ENT * PC_W;

    logic              eval_pulse;
    logic [CYC_W-1:0]  cyc_win;
    logic [CYC_W-1:0]  cyc_thr;
    logic [N_ENT-1:0]  vld_vec;
    logic [N_ENT-1:0]  hit_vec;
    logic [N_ENT-1:0]  del_vec;
    logic [N_ENT-1:0]  grant;
    logic [LIST_W-1:0] tag_flat;
    logic              alloc_ok;

    dlt_window #(.WINDOW(WINDOW), .RET_W(RET_W), .CYC_W(CYC_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .ret_cnt (ret_cnt),
        .eval    (eval_pulse),
        .cyc_win (cyc_win)
    );

    dlt_alloc #(.N(N_ENT)) u_alloc (
        .free  (~vld_vec),
        .grant (grant)
    );

    // threshold and allocation enable
    always_comb begin
        cyc_thr  = cyc_win >> frac_sh;
        alloc_ok = ld_valid && ld_l2miss && !(|hit_vec) && !eval_pulse;
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        dlt_entry #(
            .PC_W(PC_W), .LAT_W(LAT_W), .EXEC_W(EXEC_W),
            .SUM_W(SUM_W), .CYC_W(CYC_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_valid (ld_valid),
            .ld_pc    (ld_pc),
            .ld_miss  (ld_l2miss),
            .ld_lat   (ld_lat),
            .alloc    (alloc_ok && grant[i]),
            .eval     (eval_pulse),
            .thr      (cyc_thr),
            .min_exec (min_exec),
            .vld      (vld_vec[i]),
            .tag      (tag_flat[i*PC_W +: PC_W]),
            .hit      (hit_vec[i]),
            .delinq   (del_vec[i])
        );
    end

    // publish the result list and strobe at each evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_mask  <= '0;
            res_pc    <= '0;
        end else begin
            res_valid <= eval_pulse;
            if (eval_pulse) begin
                res_mask <= del_vec;
                res_pc   <= tag_flat;
            end
        end
    end
endmodule

// File: rtl/dlt_table_chk.sv
// Module dlt_table_chk: cycle-level properties of the delinquent load table,
// bound into every dlt_table instance.
// Assumes: rst_n is held low for at least one clock edge at start-up.
module dlt_table_chk #(
    parameter int N_ENT = 16,
    parameter int PC_W  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ld_valid,
    input logic                  ld_l2miss,
    input logic                  eval_pulse,
    input logic                  res_valid,
    input logic [N_ENT-1:0]      res_mask,
    input logic [N_ENT-1:0]      vld_vec,
    input logic [N_ENT*PC_W-1:0] tag_flat
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (res_valid == 1'b0 && vld_vec == '0 && res_mask == '0));

    // R2
    miss_only_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && ld_l2miss) |=> ((vld_vec & ~$past(vld_vec)) == '0));

    // R3
    one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(vld_vec & ~$past(vld_vec)) <= 1));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&vld_vec) && !eval_pulse) |=> ((&vld_vec) && $stable(tag_flat)));

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    survivors_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_pulse |=> (vld_vec == res_mask));

    // R9
    eval_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_pulse |=> ((vld_vec & ~$past(vld_vec)) == '0));

    // R10
    list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_pulse |=> $stable(res_mask));
endmodule

bind dlt_table dlt_table_chk #(.N_ENT(N_ENT), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_l2miss  (ld_l2miss),
    .eval_pulse (eval_pulse),
    .res_valid  (res_valid),
    .res_mask   (res_mask),
    .vld_vec    (vld_vec),
    .tag_flat   (tag_flat)
);

// File: tb/tb_dlt_table.sv
// Bench for dlt_table: directed windows followed by random windows. Every
// output is compared with a requirement-level model kept in this bench.
module tb_dlt_table;
    localparam int N   = 16;
    localparam int WIN = 131072;
    localparam int SAT = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic        ld_l2miss = 1'b0;
    logic [11:0] ld_lat = '0;
    logic [3:0]  ret_cnt = '0;
    logic [4:0]  frac_sh = '0;
    logic [15:0] min_exec = '0;
    logic        res_valid;
    logic [N-1:0]    res_mask;
    logic [N*32-1:0] res_pc;

    dlt_table dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_l2miss(ld_l2miss), .ld_lat(ld_lat), .ret_cnt(ret_cnt),
        .frac_sh(frac_sh), .min_exec(min_exec), .res_valid(res_valid),
        .res_mask(res_mask), .res_pc(res_pc)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    bit          m_vld [N];
    logic [31:0] m_tag [N];
    int          m_exec [N];
    int          m_lat [N];
    int          m_icnt = 0;
    int          m_cyc = 0;
    bit          exp_rv = 1'b0;
    logic [N-1:0] exp_mask = '0;
    logic [31:0] exp_pc [N];
    bit          last_eval = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // requirement-level model of one clock edge
    task automatic model_step(input bit v, input logic [31:0] pc, input bit miss,
                              input int lat, input int ret);
        bit ev;
        int thr;
        int h;
        ev = (m_icnt + ret >= WIN);
        last_eval = ev;
        exp_rv = ev;
        if (ev) begin
            thr = (m_cyc + 1) >> frac_sh;
            for (int i = 0; i < N; i++) begin
                exp_mask[i] = m_vld[i] && (m_lat[i] > thr) && (m_exec[i] > int'(min_exec));
                exp_pc[i] = m_tag[i];
                m_vld[i] = exp_mask[i];
                m_exec[i] = 0;
                m_lat[i] = 0;
            end
            m_icnt = 0;
            m_cyc = 0;
        end else begin
            m_icnt += ret;
            m_cyc++;
            if (v) begin
                h = -1;
                for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pc) h = i;
                if (h >= 0) begin
                    m_exec[h] = (m_exec[h] + 1 > SAT) ? SAT : m_exec[h] + 1;
                    if (miss) m_lat[h] = (m_lat[h] + lat > SAT) ? SAT : m_lat[h] + lat;
                end else if (miss) begin
                    for (int i = 0; i < N; i++) begin
                        if (!m_vld[i] && h < 0) begin
                            h = i;
                            m_vld[i] = 1'b1;
                            m_tag[i] = pc;
                            m_exec[i] = 1;
                            m_lat[i] = lat;
                        end
                    end
                end
            end
        end
    endtask

    // compare outputs with the model after the previous edge
    task automatic compare();
        check(32'(res_valid), 32'(exp_rv), "R6 strobe");
        check(32'(res_mask), 32'(exp_mask), exp_rv ? "R7 mask" : "R10 held mask");
        if (exp_rv)
            for (int i = 0; i < N; i++)
                if (exp_mask[i]) check(res_pc[i*32 +: 32], exp_pc[i], "R3 slot pc");
    endtask

    task automatic tick(input bit v, input logic [31:0] pc, input bit miss,
                        input int lat, input int ret);
        @(negedge clk);
        compare();
        ld_valid = v;
        ld_pc = pc;
        ld_l2miss = miss;
        ld_lat = 12'(lat);
        ret_cnt = 4'(ret);
        model_step(v, pc, miss, lat, ret);
    endtask

    // idle until the window ends; optionally present a load in the eval cycle
    task automatic run_to_eval(input int ret, input bit eval_load, input logic [31:0] pc);
        while (m_icnt + ret < WIN) tick(1'b0, '0, 1'b0, 0, ret);
        tick(eval_load, pc, 1'b1, 4095, ret);
        tick(1'b0, '0, 1'b0, 0, ret);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_exec[i] = 0; m_lat[i] = 0; exp_pc[i] = '0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(32'(res_valid), 0, "R1 res_valid");
        check(32'(res_mask), 0, "R1 res_mask");
        rst_n = 1'b1;

        // window 1: threshold = window cycles, minimum count 1, 4 per cycle
        frac_sh = 5'd0;
        min_exec = 16'd1;
        // R2: non-missing loads allocate nothing
        for (int k = 0; k < 10; k++) tick(1'b1, 32'h80, 1'b0, 0, 4);
        // R3: fill slots in arrival order
        for (int k = 0; k < 16; k++) tick(1'b1, 32'h100 + 32'(k*4), 1'b1, 10, 4);
        // R4: table full, new PCs dropped
        for (int k = 0; k < 5; k++) tick(1'b1, 32'h900 + 32'(k*4), 1'b1, 4095, 4);
        // R11: 18 more hits of 4095 saturate the 16-bit sum
        for (int k = 0; k < 18; k++) tick(1'b1, 32'h100, 1'b1, 4095, 4);
        // R5: hits below the threshold
        for (int k = 0; k < 3; k++) tick(1'b1, 32'h104, 1'b1, 4095, 4);
        tick(1'b1, 32'h108, 1'b1, 4095, 4);
        // R9: a miss in the eval cycle must not be recorded
        run_to_eval(4, 1'b1, 32'hA00);
        check(32'(res_mask), 32'h1, "R11 saturated entry delinquent");
        check(res_pc[31:0], 32'h100, "R2 first miss owns slot 0");

        // window 2: threshold = cycles >> 3
        frac_sh = 5'd3;
        // R8 and R9: slot 1 is free again and gets 0xB00, not 0xA00
        tick(1'b1, 32'hB00, 1'b1, 100, 4);
        tick(1'b1, 32'hB00, 1'b1, 4095, 4);
        tick(1'b1, 32'hB00, 1'b1, 4095, 4);
        // R8: survivor's counters were cleared, one miss is not enough
        tick(1'b1, 32'h100, 1'b1, 4095, 4);
        run_to_eval(4, 1'b0, '0);
        check(32'(res_mask), 32'h2, "R8 cleared survivor, R5 counted hits");
        check(res_pc[63:32], 32'hB00, "R9 eval-cycle load ignored");

        // windows 3 and 4: random stimulus
        min_exec = 16'd2;
        for (int w = 0; w < 2; w++) begin
            last_eval = 1'b0;
            while (!last_eval)
                tick(1'($urandom % 2), 32'h4000 + 32'(($urandom % 24) * 4),
                     1'($urandom % 2), int'($urandom % 4096), 1 + int'($urandom % 15));
            tick(1'b0, '0, 1'b0, 0, 1);
        end
        tick(1'b0, '0, 1'b0, 0, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule